// File: doc/BRIEF.md
# Serial Register-Access Slave with CRC-8 Protection

This block lets an external host read and write a small bank of 8-bit registers over a four-wire serial link: chip select, serial clock, serial data in and an open-drain serial data out. Each transfer is one frame, bounded by chip select. A frame carries a command bit, a 7-bit register address and a data byte. It can be extended by a CRC-8 byte that guards writes. The slave always starts its reply with a fixed alignment byte, so the host can confirm that it is in step with the slave. After that byte the slave returns the addressed register and, in CRC mode, a checksum.

The serial pins are oversampled by a faster system clock through synchronizers. Edges are detected in the system clock domain. Data in is taken on serial-clock rising edges and data out changes on falling edges, which suits clock-polarity/phase modes 0 and 3. The data-out pin is modelled as a pull-low enable: when the enable is high the line is driven low, and otherwise an external pull-up holds it high.

The bank holds four registers:
- a switch-control byte that appears on an output port;
- an error-configuration register;
- a sticky error-flag register;
- a read-only identification byte.

Three protocol checks feed the error flags: a wrong clock count, an invalid address, and a CRC mismatch.

Top module: `spi_regbank_slave`

## Requirements
- R1: On the first 8 serial-clock falling edges of every frame, SDO shows the byte 0x25, MSB first. SDO is only ever pulled low (the enable is high for a 0 bit); a 1 bit releases the line.
- R2: A frame whose first bit is 1 is a read. On falling edges 9 to 16, SDO shows the register addressed by bits 2 to 8, MSB first. The register contents are sampled on the 8th rising edge. The data bits the host sends in a read have no effect on any register.
- R3: A frame whose first bit is 0 is a write. With CRC disabled, a write frame of exactly 16 rising edges stores bits 9 to 16 into the addressed register when chip select rises. Register 0x00 drives `sw_ctrl_o`.
- R4: Register map:
  - 0x00 is switch control, read/write, reset value 0x00.
  - 0x01 is the error configuration, read/write, reset value 0x06. Bit 0 enables CRC, bit 1 enables the clock-count check and bit 2 enables the address check. The upper bits read as 0.
  - 0x02 holds the error flags. Bit 0 is the CRC error, bit 1 the clock-count error and bit 2 the address error.
  - 0x03 is a read-only identity byte, 0xA7.
- R5: The CRC is CRC-8 with polynomial 0x07 and seed 0. It is computed MSB first over the 16 payload bits: command, address, data. With CRC enabled (the bit is sampled at the start of the frame), a write needs exactly 24 rising edges. The write is stored only if the last 8 bits equal the CRC; on a mismatch nothing is written and flag bit 0 is set.
- R6: In a CRC-enabled frame, SDO shows on falling edges 17 to 24 the CRC of {command bit, address, register data sent on edges 9 to 16}, MSB first. In a frame without CRC, SDO is released after edge 16.
- R7: A frame that ends with a rising-edge count other than 16 (or 24 in CRC mode) writes nothing. It sets flag bit 1 if the clock-count check is enabled.
- R8: A read of an address above 0x03, or a write to an address above 0x02, is dropped. It sets flag bit 2 if the address check is enabled. A read of an unimplemented address returns 0x00.
- R9: Error flags stay set until a write to register 0x02 with a 1 in the matching data bit clears them. Flags written with 0 are kept.
- R10: While chip select is high, SDO is released within four system clocks.
- R11: After reset, the switch-control output is 0x00, SDO is released, CRC is disabled and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| cs_n_i | input | 1 | Active-low chip select bounding one frame |
| sdo_oe_o | output | 1 | Pull-low enable for the open-drain serial data out |
| sw_ctrl_o | output | 8 | Contents of the switch-control register |

## Verification
The bench checks frames one clock short and one clock long in both frame lengths. A slave that committed on the 16th edge without waiting for the end of the frame would let a 17-clock write through, and one that counted badly would flag good frames. It sends writes with a corrupted CRC and compares the returned CRC bit by bit. A wrong polynomial, seed or bit order would show up as a mismatched checksum byte or as a rejected good write. It also writes to the read-only identity byte and to unmapped addresses, and clears flags with partial masks: a register bank that decoded addresses too loosely or cleared flags on any write would change the wrong register or lose a flag.

// File: rtl/srb_pkg.sv
package srb_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 7;
    localparam int PAYLOAD_W   = 1 + ADDR_W + DATA_W;
    localparam int CRC_W       = 8;
    localparam int FRAME_SHORT = PAYLOAD_W;
    localparam int FRAME_LONG  = PAYLOAD_W + CRC_W;
    localparam int FLAG_W      = 3;

    localparam logic [CRC_W-1:0]  CRC_POLY   = 8'h07;
    localparam logic [CRC_W-1:0]  CRC_SEED   = 8'h00;
    localparam logic [DATA_W-1:0] ALIGN_BYTE = 8'h25;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_SWITCH = 7'h00;
    localparam logic [ADDR_W-1:0] ADDR_ERRCFG = 7'h01;
    localparam logic [ADDR_W-1:0] ADDR_ERRFLG = 7'h02;
    localparam logic [ADDR_W-1:0] ADDR_IDENT  = 7'h03;

    // Flag bit positions
    localparam int FLAG_CRC  = 0;
    localparam int FLAG_CNT  = 1;
    localparam int FLAG_ADDR = 2;

    // Error configuration; packed so that crc_en is bit 0
    typedef struct packed {
        logic addr_chk;
        logic cnt_chk;
        logic crc_en;
    } srb_cfg_t;

    // One completed frame, emitted by the frame engine for one cycle
    typedef struct packed {
        logic              valid;
        logic              count_ok;
        logic              crc_ok;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } srb_event_t;

    function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [CRC_W-1:0] crc8_word(input logic [PAYLOAD_W-1:0] w);
        logic [CRC_W-1:0] c;
        c = CRC_SEED;
        for (int i = PAYLOAD_W - 1; i >= 0; i--) begin
            c = crc8_step(c, w[i]);
        end
        return c;
    endfunction

    function automatic logic addr_readable(input logic [ADDR_W-1:0] a);
        return (a == ADDR_SWITCH) || (a == ADDR_ERRCFG) ||
               (a == ADDR_ERRFLG) || (a == ADDR_IDENT);
    endfunction

    function automatic logic addr_writable(input logic [ADDR_W-1:0] a);
        return (a == ADDR_SWITCH) || (a == ADDR_ERRCFG) || (a == ADDR_ERRFLG);
    endfunction

endpackage

// File: rtl/srb_input_sync.sv
module srb_input_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/srb_frame_engine.sv
module srb_frame_engine
    import srb_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  srb_cfg_t          cfg,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo_oe,
    output srb_event_t        evt
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(1 + ADDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(FRAME_SHORT);
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(FRAME_LONG);
    localparam logic [CNT_W-1:0] BYTE1_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BYTE2_END = CNT_W'(2 * DATA_W);
    localparam logic [CNT_W-1:0] BYTE3_END = CNT_W'(3 * DATA_W);

    logic                  sclk_q, cs_q;
    logic [CNT_W-1:0]      rcnt, fcnt;
    logic [FRAME_LONG-1:0] shreg;
    logic [ADDR_W:0]       hdr_q;
    logic [DATA_W-1:0]     rdat_q;
    logic                  crc_mode_q;
    logic                  oe_q;

    logic cs_active, rise, fall, start, stop;
    logic [DATA_W-1:0]    tx_byte;
    logic                 tx_bit;
    logic [PAYLOAD_W-1:0] payload;
    logic [CRC_W-1:0]     rx_crc;
    srb_event_t           evt_next;

    assign cs_active = ~cs_n_s;
    assign rise      = cs_active &  sclk_s & ~sclk_q;
    assign fall      = cs_active & ~sclk_s &  sclk_q;
    assign start     =  cs_q & ~cs_n_s;
    assign stop      = ~cs_q &  cs_n_s;

    // Address seen on the header's last rising edge
    assign rd_addr = {shreg[ADDR_W-2:0], sdi_s};

    // Outgoing bit for the falling edge about to happen (index fcnt)
    always_comb begin
        if (fcnt < BYTE1_END)
            tx_byte = ALIGN_BYTE;
        else if (fcnt < BYTE2_END)
            tx_byte = rdat_q;
        else if (fcnt < BYTE3_END && crc_mode_q)
            tx_byte = crc8_word({hdr_q, rdat_q});
        else
            tx_byte = '1;
        tx_bit = tx_byte[~fcnt[2:0]];
    end

    // Frame completion summary
    always_comb begin
        payload = crc_mode_q ? shreg[FRAME_LONG-1:CRC_W] : shreg[PAYLOAD_W-1:0];
        rx_crc  = shreg[CRC_W-1:0];
        evt_next.valid    = stop;
        evt_next.count_ok = (rcnt == (crc_mode_q ? CNT_LONG : CNT_SHORT));
        evt_next.crc_ok   = ~crc_mode_q | (crc8_word(payload) == rx_crc);
        evt_next.wr       = ~payload[PAYLOAD_W-1];
        evt_next.addr     = payload[PAYLOAD_W-2:DATA_W];
        evt_next.data     = payload[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b1;
            cs_q       <= 1'b1;
            rcnt       <= '0;
            fcnt       <= '0;
            shreg      <= '0;
            hdr_q      <= '0;
            rdat_q     <= '0;
            crc_mode_q <= 1'b0;
            oe_q       <= 1'b0;
            evt        <= '0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            evt    <= evt_next;
            if (start) begin
                rcnt       <= '0;
                fcnt       <= '0;
                shreg      <= '0;
                crc_mode_q <= cfg.crc_en;
                oe_q       <= 1'b0;
            end else if (cs_active) begin
                if (rise) begin
                    shreg <= {shreg[FRAME_LONG-2:0], sdi_s};
                    if (rcnt != CNT_MAX) rcnt <= rcnt + 1'b1;
                    if (rcnt == HDR_LAST) begin
                        hdr_q  <= {shreg[ADDR_W-1:0], sdi_s};
                        rdat_q <= rd_data;
                    end
                end
                if (fall) begin
                    if (fcnt != CNT_MAX) fcnt <= fcnt + 1'b1;
                    oe_q <= ~tx_bit;
                end
            end else begin
                oe_q <= 1'b0;
            end
        end
    end

    assign sdo_oe = oe_q;

endmodule

// File: rtl/srb_regbank.sv
module srb_regbank
    import srb_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE  = 8'hA7,
    parameter logic [2:0]        CFG_RESET = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  srb_event_t        evt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output srb_cfg_t          cfg,
    output logic [DATA_W-1:0] sw_ctrl,
    output logic [FLAG_W-1:0] flags
);

    localparam int CFG_W = $bits(srb_cfg_t);

    logic [FLAG_W-1:0] flag_set, flag_clr;
    logic              wr_sw, wr_cfg, addr_ok;

    always_comb begin
        case (rd_addr)
            ADDR_SWITCH: rd_data = sw_ctrl;
            ADDR_ERRCFG: rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg};
            ADDR_ERRFLG: rd_data = {{(DATA_W-FLAG_W){1'b0}}, flags};
            ADDR_IDENT:  rd_data = ID_VALUE;
            default:     rd_data = '0;
        endcase
    end

    always_comb begin
        flag_set = '0;
        flag_clr = '0;
        wr_sw    = 1'b0;
        wr_cfg   = 1'b0;
        addr_ok  = evt.wr ? addr_writable(evt.addr) : addr_readable(evt.addr);
        if (evt.valid) begin
            if (!evt.count_ok) begin
                flag_set[FLAG_CNT] = cfg.cnt_chk;
            end else if (!addr_ok) begin
                flag_set[FLAG_ADDR] = cfg.addr_chk;
            end else if (evt.wr) begin
                if (!evt.crc_ok) begin
                    flag_set[FLAG_CRC] = 1'b1;
                end else begin
                    wr_sw    = (evt.addr == ADDR_SWITCH);
                    wr_cfg   = (evt.addr == ADDR_ERRCFG);
                    flag_clr = (evt.addr == ADDR_ERRFLG) ? evt.data[FLAG_W-1:0] : '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_ctrl <= '0;
            cfg     <= srb_cfg_t'(CFG_RESET);
            flags   <= '0;
        end else begin
            if (wr_sw)  sw_ctrl <= evt.data;
            if (wr_cfg) cfg     <= srb_cfg_t'(evt.data[CFG_W-1:0]);
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import srb_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                CNT_W       = 6,
    parameter logic [DATA_W-1:0] ID_VALUE    = 8'hA7,
    parameter logic [2:0]        CFG_RESET   = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              cs_n_i,
    output logic              sdo_oe_o,
    output logic [DATA_W-1:0] sw_ctrl_o
);

    logic              cs_n_s, sclk_s, sdi_s;
    srb_cfg_t          cfg;
    srb_event_t        evt;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [FLAG_W-1:0] flags;

    srb_input_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b111)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({cs_n_i, sclk_i, sdi_i}),
        .q  ({cs_n_s, sclk_s, sdi_s})
    );

    srb_frame_engine #(
        .CNT_W(CNT_W)
    ) u_engine (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (cs_n_s),
        .sclk_s (sclk_s),
        .sdi_s  (sdi_s),
        .cfg    (cfg),
        .rd_data(rd_data),
        .rd_addr(rd_addr),
        .sdo_oe (sdo_oe_o),
        .evt    (evt)
    );

    srb_regbank #(
        .ID_VALUE (ID_VALUE),
        .CFG_RESET(CFG_RESET)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .cfg    (cfg),
        .sw_ctrl(sw_ctrl_o),
        .flags  (flags)
    );

endmodule

// File: rtl/srb_checker.sv
module srb_checker
    import srb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n_i,
    input logic              sdo_oe_o,
    input logic [DATA_W-1:0] sw_ctrl_o,
    input srb_cfg_t          cfg,
    input logic [FLAG_W-1:0] flags,
    input srb_event_t        evt
);

    // R10: chip select held high releases the data line
    p_sdo_release_r10: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);

    // R3: switch control only changes on a write frame to its address
    p_sw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(evt.valid && evt.wr && evt.addr == ADDR_SWITCH) |=> $stable(sw_ctrl_o));

    // R9: flags never drop without a write to the flag register
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !(evt.valid && evt.wr && evt.addr == ADDR_ERRFLG) |=> ((flags & $past(flags)) == $past(flags)));

    // R7: a frame with a wrong clock count changes no register
    p_badcount_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !evt.count_ok) |=> ($stable(sw_ctrl_o) && $stable(cfg)));

    // R5: a CRC mismatch blocks the write
    p_crc_block_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.wr && !evt.crc_ok) |=> ($stable(sw_ctrl_o) && $stable(cfg)));

    // R8: a write to the identity byte changes no register
    p_ro_ident_r8: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.wr && evt.addr == ADDR_IDENT) |=> ($stable(sw_ctrl_o) && $stable(cfg)));

endmodule

bind spi_regbank_slave srb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n_i   (cs_n_i),
    .sdo_oe_o (sdo_oe_o),
    .sw_ctrl_o(sw_ctrl_o),
    .cfg      (cfg),
    .flags    (flags),
    .evt      (evt)
);

// File: tb/tb_spi_regbank_slave.sv
module tb_spi_regbank_slave;

    localparam int HALF = 6;  // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk_i = 1'b1;
    logic       sdi_i = 1'b0;
    logic       cs_n_i = 1'b1;
    logic       sdo_oe_o;
    logic [7:0] sw_ctrl_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state
    logic [7:0] m_sw;
    logic [2:0] m_cfg;
    logic [2:0] m_flags;
    logic [23:0] got;

    spi_regbank_slave dut (
        .clk      (clk),
        .rst      (rst),
        .sclk_i   (sclk_i),
        .sdi_i    (sdi_i),
        .cs_n_i   (cs_n_i),
        .sdo_oe_o (sdo_oe_o),
        .sw_ctrl_o(sw_ctrl_o)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [15:0] w);
        logic [7:0] c;
        logic fb;
        c = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            fb = c[7] ^ w[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [7:0] m_read(input logic [6:0] a);
        case (a)
            7'h00:   return m_sw;
            7'h01:   return {5'b0, m_cfg};
            7'h02:   return {5'b0, m_flags};
            7'h03:   return 8'hA7;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Mode 3 frame: bit i of the frame is word[23-i]
    task automatic do_frame(input logic [23:0] word, input int n);
        got = '1;
        cs_n_i = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            sclk_i = 1'b0;
            sdi_i  = (i < 24) ? word[23 - i] : 1'b0;
            wait_clk(HALF);
            if (i < 24) got[23 - i] = sdo_oe_o ? 1'b0 : 1'b1;
            sclk_i = 1'b1;
            wait_clk(HALF);
        end
        wait_clk(2);
        cs_n_i = 1'b1;
        wait_clk(8);
    endtask

    task automatic run_frame(input logic rd, input logic [6:0] a, input logic [7:0] d,
                             input int n, input logic bad_crc, input string tag);
        logic        crcm;
        logic [15:0] payload;
        logic [7:0]  crc, rv;
        logic [23:0] word, exp, mask;
        int          lim;
        crcm    = m_cfg[0];
        payload = {rd, a, d};
        crc     = ref_crc(payload) ^ (bad_crc ? 8'h5A : 8'h00);
        word    = crcm ? {payload, crc} : {payload, 8'h00};
        rv      = m_read(a);
        exp     = {8'h25, rv, crcm ? ref_crc({rd, a, rv}) : 8'hFF};
        do_frame(word, n);
        lim  = (n < 24) ? n : 24;
        mask = ~(24'hFFFFFF >> lim);
        if (n >= 8)
            chk(got[23:16] == 8'h25, {tag, " R1 align"}, {24'h0, got[23:16]}, 32'h25);
        chk((got & mask) == (exp & mask), {tag, " R2/R6 sdo stream"}, {8'h0, got & mask}, {8'h0, exp & mask});
        // Model update at frame end
        if (n != (crcm ? 24 : 16)) begin
            if (m_cfg[1]) m_flags[1] = 1'b1;
        end else if (rd ? (a > 7'h03) : (a > 7'h02)) begin
            if (m_cfg[2]) m_flags[2] = 1'b1;
        end else if (!rd) begin
            if (crcm && bad_crc) m_flags[0] = 1'b1;
            else case (a)
                7'h00: m_sw = d;
                7'h01: m_cfg = d[2:0];
                7'h02: m_flags = m_flags & ~d[2:0];
                default: ;
            endcase
        end
        chk(sw_ctrl_o == m_sw, {tag, " R3 sw_ctrl"}, {24'h0, sw_ctrl_o}, {24'h0, m_sw});
        chk(sdo_oe_o == 1'b0, {tag, " R10 release"}, {31'h0, sdo_oe_o}, 32'h0);
    endtask

    task automatic read_chk(input logic [6:0] a, input logic [7:0] expv, input string tag);
        run_frame(1'b1, a, 8'hC3, m_cfg[0] ? 24 : 16, 1'b0, tag);
        chk(got[15:8] == expv, tag, {24'h0, got[15:8]}, {24'h0, expv});
    endtask

    initial begin
        logic [6:0] ra;
        logic [7:0] rdat;
        int         rn, sel;
        logic       rrd, rbad;
        m_sw = 8'h00; m_cfg = 3'b110; m_flags = 3'b000;
        void'($urandom(32'h5EED_1234));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R11 reset state
        chk(sw_ctrl_o == 8'h00, "R11 sw_ctrl after reset", {24'h0, sw_ctrl_o}, 32'h0);
        chk(sdo_oe_o == 1'b0, "R11 sdo released after reset", {31'h0, sdo_oe_o}, 32'h0);
        read_chk(7'h01, 8'h06, "R4 R11 cfg reset");
        read_chk(7'h02, 8'h00, "R11 flags reset");
        read_chk(7'h03, 8'hA7, "R4 ident");

        // R3 write then read back; R2 read with SDI data ignored
        run_frame(1'b0, 7'h00, 8'h5C, 16, 1'b0, "R3 write sw");
        read_chk(7'h00, 8'h5C, "R2 readback sw");
        run_frame(1'b1, 7'h00, 8'hFF, 16, 1'b0, "R2 read ignores sdi");
        chk(sw_ctrl_o == 8'h5C, "R2 sw unchanged", {24'h0, sw_ctrl_o}, 32'h5C);

        // R8 invalid accesses
        run_frame(1'b0, 7'h03, 8'h11, 16, 1'b0, "R8 write ident");
        read_chk(7'h03, 8'hA7, "R8 ident kept");
        read_chk(7'h02, 8'h04, "R8 addr flag");
        read_chk(7'h50, 8'h00, "R8 unimplemented reads 0");

        // R9 partial clear keeps other flags
        run_frame(1'b0, 7'h00, 8'h77, 15, 1'b0, "R7 short frame");
        chk(sw_ctrl_o == 8'h5C, "R7 no write short", {24'h0, sw_ctrl_o}, 32'h5C);
        run_frame(1'b0, 7'h00, 8'h77, 17, 1'b0, "R7 long frame");
        chk(sw_ctrl_o == 8'h5C, "R7 no write long", {24'h0, sw_ctrl_o}, 32'h5C);
        read_chk(7'h02, 8'h06, "R7 count flag");
        run_frame(1'b0, 7'h02, 8'h02, 16, 1'b0, "R9 clear count only");
        read_chk(7'h02, 8'h04, "R9 addr flag kept");
        run_frame(1'b0, 7'h02, 8'h04, 16, 1'b0, "R9 clear addr");
        read_chk(7'h02, 8'h00, "R9 all clear");

        // R7 count check disabled
        run_frame(1'b0, 7'h01, 8'h04, 16, 1'b0, "R4 cfg no count chk");
        run_frame(1'b0, 7'h00, 8'h12, 18, 1'b0, "R7 long frame unchecked");
        read_chk(7'h02, 8'h00, "R7 no flag when disabled");

        // R5/R6 CRC mode
        run_frame(1'b0, 7'h01, 8'h07, 16, 1'b0, "R5 enable crc");
        run_frame(1'b0, 7'h00, 8'hA5, 24, 1'b0, "R5 good crc write");
        chk(sw_ctrl_o == 8'hA5, "R5 good crc stored", {24'h0, sw_ctrl_o}, 32'hA5);
        run_frame(1'b0, 7'h00, 8'h3C, 24, 1'b1, "R5 bad crc write");
        chk(sw_ctrl_o == 8'hA5, "R5 bad crc blocked", {24'h0, sw_ctrl_o}, 32'hA5);
        read_chk(7'h02, 8'h01, "R5 crc flag");
        read_chk(7'h00, 8'hA5, "R6 crc read");
        run_frame(1'b0, 7'h00, 8'h99, 16, 1'b0, "R7 16 clk in crc mode");
        chk(sw_ctrl_o == 8'hA5, "R7 no write 16 in crc mode", {24'h0, sw_ctrl_o}, 32'hA5);
        run_frame(1'b0, 7'h02, 8'h07, 24, 1'b0, "R9 clear all crc");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            sel  = $urandom_range(0, 9);
            ra   = (sel < 8) ? 7'($urandom_range(0, 3)) : 7'($urandom_range(0, 127));
            rdat = 8'($urandom_range(0, 255));
            rrd  = ($urandom_range(0, 1) == 1);
            if (ra == 7'h01 && !rrd) rdat[2:0] = 3'($urandom_range(0, 7));
            rn   = m_cfg[0] ? 24 : 16;
            if ($urandom_range(0, 7) == 0) rn = rn + (($urandom_range(0, 1) == 1) ? 1 : -1);
            rbad = ($urandom_range(0, 5) == 0);
            run_frame(rrd, ra, rdat, rn, rbad, "R3 R5 R8 random");
        end
        read_chk(7'h02, {5'b0, m_flags}, "R9 final flags");
        read_chk(7'h01, {5'b0, m_cfg}, "R4 final cfg");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule